// File: doc/BRIEF.md
# Clock Divider and Output Bank for a Zero-Delay Clock Driver

This block is the digital back end of a zero-delay clock driver. A fast source clock, taken either from an oscillator input or from one of two reference clock inputs, passes through an optional divide-by-two prescaler. It then drives a bank of registered clock outputs: five matched true outputs, one complemented output, a double-rate output and a half-rate output. The analog loop (phase detector, charge pump, filter, oscillator, lock detect) lies outside the block and connects only through the oscillator clock input.

A single active-low control, `oeRstN`, disables every output and clears the divider registers at once. Its release is synchronized to the source clock, so all outputs turn on at the same edge. Three-state pads are modelled as one drive-enable bit per output. A disabled output's clock value is forced to 0. A bypass mode replaces the oscillator with the selected reference clock and complements the polarity of every output.

Top module: `clkdist_top`

## Requirements
- R1: While enabled, the five true outputs `qOut` are identical at all times and `qBarOut` is their complement.
- R2: With `halfSpeed` = 0, the periods of `dblOut`, the `qOut` bank and `halfOut` are 2, 4 and 8 source clock periods.
- R3: `halfOut` changes only on edges where the true outputs make their active transition (0 to 1 in normal polarity), so its edges stay aligned with the bank.
- R4: With `halfSpeed` = 1, an extra divide-by-two stage sits ahead of the output registers, and every output period doubles to 4, 8 and 16 source clock periods.
- R5: While `oeRstN` is 0, all eight `drvEn` bits are 0 and every clock output is 0. This takes effect asynchronously, without waiting for a clock edge.
- R6: After `oeRstN` rises, all eight `drvEn` bits rise together on the SYNC_STAGES-th rising edge of the source clock. The default is the 2nd edge.
- R7: In normal mode (`oscEn` = 1), at the edge where outputs become enabled, `qOut` is all 0, `qBarOut` is 1, `dblOut` is 0 and `halfOut` is 0.
- R8: With `oscEn` = 0, the source clock is `refClk1` when `refSel` = 1 and `refClk0` when `refSel` = 0. Output periods follow that reference's period.
- R9: With `oscEn` = 0, every output is the complement of its normal-mode value. At enable, `qOut` is all 1, `qBarOut` is 0, `dblOut` is 1 and `halfOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vcoClk | input | 1 | Fast clock from the oscillator |
| refClk0 | input | 1 | Reference clock 0, used in bypass mode |
| refClk1 | input | 1 | Reference clock 1, used in bypass mode |
| refSel | input | 1 | Selects refClk1 (1) or refClk0 (0) in bypass mode |
| oscEn | input | 1 | 1 = oscillator source, normal polarity; 0 = bypass, complemented outputs |
| halfSpeed | input | 1 | 1 inserts an extra divide-by-two ahead of the output registers |
| oeRstN | input | 1 | Active-low output disable and divider reset |
| qOut | output | NUM_TRUE | Matched true clock outputs |
| qBarOut | output | 1 | Complemented clock output |
| dblOut | output | 1 | Double-rate clock output |
| halfOut | output | 1 | Half-rate clock output |
| drvEn | output | NUM_TRUE+3 | Drive enables: [NUM_TRUE-1:0] true outputs, then qBarOut, dblOut, halfOut |

## Verification
The bench builds the block with its defaults: NUM_TRUE = 5 and SYNC_STAGES = 2. This yields an eight-output bank whose every bit can be compared on each sample, and a two-edge release that can be counted exactly. The bench sweeps all four combinations of `halfSpeed` and `oscEn`, using both reference selections in bypass. The three source periods are unrelated (20, 30 and 46 ns), so the measured output periods show which clock was actually used. In each run the bench checks the reset state, the enable edge, the values at enable, the period of each output and alignment against the half-rate output. It also checks an asynchronous disable in the middle of a run.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;

  // Strobes from the control section to the output datapath.
  typedef struct packed {
    logic run;      // divider released from reset, outputs enabled
    logic advance;  // step the output registers this edge
    logic invert;   // bypass polarity: complement every output
  } ctrlStrobe_t;

endpackage

// File: rtl/clkdist_ctrl.sv
module clkdist_ctrl
  import clkdist_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        srcClk,
  input  logic        oeRstN,
  input  logic        oscEn,
  input  logic        halfSpeed,
  output ctrlStrobe_t strobe
);

  localparam int SyncW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SyncW-1:0] syncQ;
  logic             runQ;
  logic             prescQ;

  // Release synchronizer: asserted asynchronously, released on source edges.
  always_ff @(posedge srcClk or negedge oeRstN) begin
    if (!oeRstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SyncW-2:0], 1'b1};
    end
  end

  assign runQ = syncQ[SyncW-1];

  // Optional divide-by-two prescaler ahead of the output registers.
  always_ff @(posedge srcClk or negedge oeRstN) begin
    if (!oeRstN) begin
      prescQ <= 1'b0;
    end else if (!runQ) begin
      prescQ <= 1'b0;
    end else begin
      prescQ <= ~prescQ;
    end
  end

  always_comb begin
    strobe.run     = runQ;
    strobe.advance = runQ & (halfSpeed ? prescQ : 1'b1);
    strobe.invert  = ~oscEn;
  end

  // With the prescaler in use, advance strobes never fall on back-to-back edges.
  AST_PRESCALE_GAP: assert property (@(posedge srcClk) disable iff (!oeRstN)
    (halfSpeed && strobe.advance) |=> (!strobe.advance || !halfSpeed)); // R4

endmodule

// File: rtl/clkdist_datapath.sv
module clkdist_datapath
  import clkdist_pkg::*;
#(
  parameter int NUM_TRUE = 5
) (
  input  logic                  srcClk,
  input  logic                  oeRstN,
  input  ctrlStrobe_t           strobe,
  output logic [NUM_TRUE+2:0]   rawBank
);

  localparam int BankW = NUM_TRUE + 3;

  logic                dblReg;
  logic [NUM_TRUE-1:0] qBank;
  logic                qInvReg;
  logic                halfReg;

  // Double-rate register toggles on every advance.
  always_ff @(posedge srcClk or negedge oeRstN) begin
    if (!oeRstN) begin
      dblReg <= 1'b0;
    end else if (!strobe.run) begin
      dblReg <= 1'b0;
    end else if (strobe.advance) begin
      dblReg <= ~dblReg;
    end
  end

  // Matched true outputs: one register per output, each toggling on
  // the falling step of the double-rate register.
  for (genvar gi = 0; gi < NUM_TRUE; gi++) begin : gTrue
    always_ff @(posedge srcClk or negedge oeRstN) begin
      if (!oeRstN) begin
        qBank[gi] <= 1'b0;
      end else if (!strobe.run) begin
        qBank[gi] <= 1'b0;
      end else if (strobe.advance && dblReg) begin
        qBank[gi] <= ~qBank[gi];
      end
    end
  end

  // Complemented output has its own register, reset to 1.
  always_ff @(posedge srcClk or negedge oeRstN) begin
    if (!oeRstN) begin
      qInvReg <= 1'b1;
    end else if (!strobe.run) begin
      qInvReg <= 1'b1;
    end else if (strobe.advance && dblReg) begin
      qInvReg <= ~qInvReg;
    end
  end

  // Half-rate register toggles only when the Q registers rise.
  always_ff @(posedge srcClk or negedge oeRstN) begin
    if (!oeRstN) begin
      halfReg <= 1'b0;
    end else if (!strobe.run) begin
      halfReg <= 1'b0;
    end else if (strobe.advance && dblReg && !qBank[0]) begin
      halfReg <= ~halfReg;
    end
  end

  assign rawBank = {halfReg, dblReg, qInvReg, qBank};

  AST_BANK_MATCH: assert property (@(posedge srcClk) disable iff (!oeRstN)
    (qBank == {NUM_TRUE{qBank[0]}}) && (qInvReg != qBank[0])); // R1

  AST_Q_ON_DBL_FALL: assert property (@(posedge srcClk) disable iff (!oeRstN)
    (strobe.run && !$stable(qBank[0])) |-> $fell(dblReg)); // R2

  AST_HALF_ALIGN: assert property (@(posedge srcClk) disable iff (!oeRstN)
    (strobe.run && !$stable(halfReg)) |-> $rose(qBank[0])); // R3

  initial begin
    assert (BankW == $bits(rawBank)); // R1
  end

endmodule

// File: rtl/clkdist_top.sv
module clkdist_top
  import clkdist_pkg::*;
#(
  parameter int NUM_TRUE    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                vcoClk,
  input  logic                refClk0,
  input  logic                refClk1,
  input  logic                refSel,
  input  logic                oscEn,
  input  logic                halfSpeed,
  input  logic                oeRstN,
  output logic [NUM_TRUE-1:0] qOut,
  output logic                qBarOut,
  output logic                dblOut,
  output logic                halfOut,
  output logic [NUM_TRUE+2:0] drvEn
);

  localparam int BankW = NUM_TRUE + 3;

  logic             srcClk;
  ctrlStrobe_t      strobe;
  logic [BankW-1:0] rawBank;
  logic [BankW-1:0] padBank;

  // Source select: oscillator in normal mode, chosen reference in bypass.
  assign srcClk = oscEn ? vcoClk : (refSel ? refClk1 : refClk0);

  clkdist_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .srcClk    (srcClk),
    .oeRstN    (oeRstN),
    .oscEn     (oscEn),
    .halfSpeed (halfSpeed),
    .strobe    (strobe)
  );

  clkdist_datapath #(
    .NUM_TRUE(NUM_TRUE)
  ) u_dp (
    .srcClk  (srcClk),
    .oeRstN  (oeRstN),
    .strobe  (strobe),
    .rawBank (rawBank)
  );

  // Pad model: polarity applied, value forced low when the driver is off.
  assign drvEn   = {BankW{strobe.run}};
  assign padBank = drvEn & (rawBank ^ {BankW{strobe.invert}});

  assign qOut    = padBank[NUM_TRUE-1:0];
  assign qBarOut = padBank[NUM_TRUE];
  assign dblOut  = padBank[NUM_TRUE+1];
  assign halfOut = padBank[NUM_TRUE+2];

  AST_OFF_WHEN_LOW: assert property (@(posedge srcClk)
    !oeRstN |-> (drvEn == '0 && padBank == '0)); // R5

endmodule

// File: tb/clkdist_top_tb.sv
`timescale 1ns/1ps
module clkdist_top_tb;

  localparam int NT = 5;
  localparam int SS = 2;
  localparam int P_OSC = 20;
  localparam int P_R0  = 30;
  localparam int P_R1  = 46;

  logic clk = 1'b0, r0 = 1'b0, r1 = 1'b0;
  logic refSel = 1'b0, oscEn = 1'b1, halfSpeed = 1'b0, oeRstN = 1'b0;
  logic [NT-1:0] qOut;
  logic qBarOut, dblOut, halfOut;
  logic [NT+2:0] drvEn;

  int nChk = 0, nBad = 0;
  int probeSel = 0;
  logic probe;
  logic bSrc;
  bit done = 1'b0;

  always #(P_OSC/2) clk = ~clk;
  always #(P_R0/2)  r0  = ~r0;
  always #(P_R1/2)  r1  = ~r1;

  assign bSrc = oscEn ? clk : (refSel ? r1 : r0);

  always_comb begin
    case (probeSel)
      0: probe = dblOut;
      1: probe = qOut[0];
      2: probe = qBarOut;
      default: probe = halfOut;
    endcase
  end

  clkdist_top #(.NUM_TRUE(NT), .SYNC_STAGES(SS)) u_dut (
    .vcoClk(clk), .refClk0(r0), .refClk1(r1), .refSel(refSel),
    .oscEn(oscEn), .halfSpeed(halfSpeed), .oeRstN(oeRstN),
    .qOut(qOut), .qBarOut(qBarOut), .dblOut(dblOut), .halfOut(halfOut),
    .drvEn(drvEn)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runCase(input bit osc, input bit fs, input bit rs);
    int srcP, mul, cnt;
    bit inv;
    longint t0, t1;
    logic [NT+2:0] expBank;
    oeRstN = 1'b0;
    oscEn = osc; halfSpeed = fs; refSel = rs;
    inv = !osc;
    srcP = osc ? P_OSC : (rs ? P_R1 : P_R0);
    mul = fs ? 2 : 1;
    #200;
    // R5: disabled and low while reset is held
    chk("R5 drvEn in reset", drvEn, 0);
    chk("R5 outputs in reset", {halfOut, dblOut, qBarOut, qOut}, 0);
    #7 oeRstN = 1'b1;
    // R6: count source edges until the enables rise
    cnt = 0;
    while (drvEn == '0 && cnt < 10) begin
      @(posedge bSrc); #1; cnt++;
    end
    chk("R6 edges to enable", cnt, SS);
    chk("R6 all enables together", drvEn, {(NT+3){1'b1}});
    // R7 / R9: values at the enabling edge
    expBank = inv ? {1'b1, 1'b1, 1'b0, {NT{1'b1}}} : {1'b0, 1'b0, 1'b1, {NT{1'b0}}};
    chk(inv ? "R9 values at enable" : "R7 values at enable",
        {halfOut, dblOut, qBarOut, qOut}, expBank);
    // R2 / R4 / R8: periods of each output
    for (int s = 0; s < 4; s++) begin
      int ratio;
      ratio = (s == 0) ? 2 : ((s == 3) ? 8 : 4);
      probeSel = s;
      #1;
      @(posedge probe); @(posedge probe);
      t0 = $time;
      @(posedge probe);
      t1 = $time;
      chk(fs ? (osc ? "R4 period" : "R8 R4 period") : (osc ? "R2 period" : "R8 R2 period"),
          t1 - t0, longint'(srcP * ratio * mul));
      // R1: bank matched and complement present
      #1;
      chk("R1 bank identical", qOut, {NT{qOut[0]}});
      chk("R1 complement", qBarOut, !qOut[0]);
    end
    // R3: at each half-rate edge the true bank has just made its active step
    for (int k = 0; k < 2; k++) begin
      @(posedge halfOut or negedge halfOut); #1;
      chk("R3 half aligned to bank", qOut[0], !inv);
    end
    // R5: asynchronous disable mid-run
    #3 oeRstN = 1'b0;
    #1;
    chk("R5 async drvEn", drvEn, 0);
    chk("R5 async outputs", {halfOut, dblOut, qBarOut, qOut}, 0);
  endtask

  initial begin
    runCase(1'b1, 1'b0, 1'b0);
    runCase(1'b1, 1'b1, 1'b1);
    runCase(1'b0, 1'b0, 1'b0);
    runCase(1'b0, 1'b1, 1'b1);
    runCase(1'b0, 1'b1, 1'b0);
    runCase(1'b0, 1'b0, 1'b1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule